// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

This block pairs a free-running up-counter with a compare register and watches the two values for equality on every clock. The counter advances only on a count-enable tick. When the values become equal, a 4-bit mode code picks the response. The response can set, clear or toggle a single output latch. It can raise only an interrupt, or it can fire a special event. That event requests a converter start and returns the counter to zero.

In special event mode the compare register works as a programmable counter period. The converter-start strobe is asserted in the same cycle the equality is detected. The counter reset waits for the next count tick. If software rewrites the compare register before that tick so that the values no longer agree, the reset is dropped. A reset caused by the special event never counts as a counter overflow.

The unit is written as one controller state machine. In `SEQ_ARMED` it is waiting for a match. In `SEQ_SPENT` the match for the current count value has already been used. In `SEQ_HOLD` a special event has fired and a counter reset is pending.

The transitions are as follows:
- `SEQ_ARMED` moves to `SEQ_SPENT` on a match with no tick.
- `SEQ_ARMED` moves to `SEQ_HOLD` on a match with no tick in special mode.
- `SEQ_ARMED` stays in `SEQ_ARMED` on a match that coincides with a tick.
- `SEQ_SPENT` returns to `SEQ_ARMED` on a tick or on a compare write.
- `SEQ_HOLD` returns to `SEQ_ARMED` on a tick.
- `SEQ_HOLD` drops to `SEQ_SPENT` if the mode leaves special event.

Top module: `cmp_timer_unit`

## Requirements
- R1: A match (counter equals compare register) is acted on at most once per count value. While the counter holds between ticks, the match does not repeat the action or the flag. A compare-register write re-arms matching.
- R2: Mode 4'b0010 toggles the output latch on a match. The latch update is visible one clock after the match cycle.
- R3: Mode 4'b1000 sets the output latch on a match, and mode 4'b1001 clears it.
- R4: In modes 0010, 1000, 1001, 1010 and 1011, a match sets `irq_o` one clock later. `irq_o` stays set until `irq_clr_i` is pulsed, and a new match takes priority over the clear.
- R5: Mode 4'b1010 raises the flag only. `pin_oe_o` stays low and `pin_o` reads 0.
- R6: Mode 4'b1011 asserts `conv_start_o` in the match cycle itself, for one cycle, and never drives the pin.
- R7: After a special event, the first tick that finds the match still present loads the counter with 0 instead of incrementing it, and `ovf_o` is not set. This holds whether that tick falls in the match cycle or later.
- R8: If the compare register is rewritten between the special event and the next tick so that the values differ, that tick increments the counter normally.
- R9: Writing mode 4'b0000 forces the output latch to 0.
- R10: `pin_oe_o` is high only when `oe_i` is high and the mode is 0010, 1000 or 1001. `pin_o` is the latch when `pin_oe_o` is high, and 0 otherwise.
- R11: Any other mode code takes no action on a match: the flag, the latch and the strobe are unaffected.
- R12: Each tick advances the counter by one. Wrapping from all-ones to zero sets the sticky `ovf_o`, which `ovf_clr_i` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 selects the compare value, 1 selects the mode (data bits 3:0) |
| wr_data_i | input | CNT_W | Write data |
| tick_i | input | 1 | Count-enable tick |
| oe_i | input | 1 | External output enable |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| count_o | output | CNT_W | Current counter value |
| ovf_o | output | 1 | Sticky counter wrap flag |
| irq_o | output | 1 | Sticky compare interrupt flag |
| pin_o | output | 1 | Compare output pin value |
| pin_oe_o | output | 1 | Pin drive enable |
| conv_start_o | output | 1 | Converter start strobe |

## Verification
The bench builds the unit with the default `CNT_W` of 16, so the full counter is used. This lets one test tick the counter through all 65536 values. That run shows a toggle firing a second time after a wrap and shows `ovf_o` rising on a true rollover. The same width keeps the special-event reset distinct from a wrap: there, `count_o` returns to zero while `ovf_o` stays low.

// File: rtl/cmp_timer_pkg.sv
`timescale 1ns/1ps
package cmp_timer_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] MODE_OFF    = 4'b0000;
    localparam logic [MODE_W-1:0] MODE_TOGGLE = 4'b0010;
    localparam logic [MODE_W-1:0] MODE_SET    = 4'b1000;
    localparam logic [MODE_W-1:0] MODE_CLEAR  = 4'b1001;
    localparam logic [MODE_W-1:0] MODE_IRQ    = 4'b1010;
    localparam logic [MODE_W-1:0] MODE_EVENT  = 4'b1011;

    typedef enum logic [1:0] {
        SEQ_ARMED = 2'd0,
        SEQ_SPENT = 2'd1,
        SEQ_HOLD  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic drives_pin;
        logic act_set;
        logic act_clr;
        logic act_tgl;
        logic irq_en;
        logic event_en;
    } mode_dec_t;

    function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] m);
        mode_dec_t d;
        d = '0;
        unique case (m)
            MODE_TOGGLE: begin d.drives_pin = 1'b1; d.act_tgl = 1'b1; d.irq_en = 1'b1; end
            MODE_SET:    begin d.drives_pin = 1'b1; d.act_set = 1'b1; d.irq_en = 1'b1; end
            MODE_CLEAR:  begin d.drives_pin = 1'b1; d.act_clr = 1'b1; d.irq_en = 1'b1; end
            MODE_IRQ:    begin d.irq_en = 1'b1; end
            MODE_EVENT:  begin d.irq_en = 1'b1; d.event_en = 1'b1; end
            default:     d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/cmp_counter.sv
`timescale 1ns/1ps
module cmp_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             evt_reset_i,
    input  logic             ovf_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;
    logic             ovf_q;
    logic             wrap;

    assign wrap = tick_i && !evt_reset_i && (count_q == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (tick_i) begin
            if (evt_reset_i) count_q <= '0;
            else             count_q <= count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ovf_q <= 1'b0;
        else if (wrap)      ovf_q <= 1'b1;
        else if (ovf_clr_i) ovf_q <= 1'b0;
    end

    assign count_o = count_q;
    assign ovf_o   = ovf_q;
endmodule

// File: rtl/cmp_seq_fsm.sv
`timescale 1ns/1ps
module cmp_seq_fsm
    import cmp_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match_i,
    input  logic tick_i,
    input  logic cmp_wr_i,
    input  logic event_mode_i,
    output logic fire_o,
    output logic trig_o,
    output logic ctr_reset_o
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_ARMED: begin
                if (match_i && !tick_i) begin
                    if (event_mode_i) state_d = SEQ_HOLD;
                    else              state_d = SEQ_SPENT;
                end
            end
            SEQ_SPENT: begin
                if (tick_i || cmp_wr_i) state_d = SEQ_ARMED;
            end
            SEQ_HOLD: begin
                if (tick_i)             state_d = SEQ_ARMED;
                else if (!event_mode_i) state_d = SEQ_SPENT;
            end
            default: state_d = SEQ_ARMED;
        endcase
    end

    always_comb begin
        fire_o      = 1'b0;
        trig_o      = 1'b0;
        ctr_reset_o = 1'b0;
        unique case (state_q)
            SEQ_ARMED: begin
                fire_o      = match_i;
                trig_o      = match_i && event_mode_i;
                ctr_reset_o = match_i && event_mode_i && tick_i;
            end
            SEQ_HOLD: begin
                ctr_reset_o = match_i && event_mode_i && tick_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cmp_out_ctrl.sv
`timescale 1ns/1ps
module cmp_out_ctrl
    import cmp_timer_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fire_i,
    input  mode_dec_t dec_i,
    input  logic      mode_off_wr_i,
    input  logic      oe_i,
    input  logic      irq_clr_i,
    output logic      latch_o,
    output logic      pin_o,
    output logic      pin_oe_o,
    output logic      irq_o
);
    logic latch_q;
    logic irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             latch_q <= 1'b0;
        else if (mode_off_wr_i) latch_q <= 1'b0;
        else if (fire_i) begin
            if (dec_i.act_set)      latch_q <= 1'b1;
            else if (dec_i.act_clr) latch_q <= 1'b0;
            else if (dec_i.act_tgl) latch_q <= ~latch_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    irq_q <= 1'b0;
        else if (fire_i && dec_i.irq_en) irq_q <= 1'b1;
        else if (irq_clr_i)            irq_q <= 1'b0;
    end

    assign pin_oe_o = oe_i && dec_i.drives_pin;
    assign pin_o    = pin_oe_o && latch_q;
    assign latch_o  = latch_q;
    assign irq_o    = irq_q;
endmodule

// File: rtl/cmp_timer_unit.sv
`timescale 1ns/1ps
module cmp_timer_unit
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             tick_i,
    input  logic             oe_i,
    input  logic             irq_clr_i,
    input  logic             ovf_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             irq_o,
    output logic             pin_o,
    output logic             pin_oe_o,
    output logic             conv_start_o
);
    logic [CNT_W-1:0]  cmp_q;
    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  count_w;
    logic              cmp_wr, mode_wr, mode_off_wr;
    logic              match, fire, trig, ctr_reset, latch_w;
    mode_dec_t         dec;

    assign cmp_wr      = wr_en_i && !wr_addr_i;
    assign mode_wr     = wr_en_i &&  wr_addr_i;
    assign mode_off_wr = mode_wr && (wr_data_i[MODE_W-1:0] == MODE_OFF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            mode_q <= MODE_OFF;
        end else begin
            if (cmp_wr)  cmp_q  <= wr_data_i;
            if (mode_wr) mode_q <= wr_data_i[MODE_W-1:0];
        end
    end

    assign dec   = decode_mode(mode_q);
    assign match = (count_w == cmp_q);

    cmp_counter #(.CNT_W(CNT_W)) ctr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .evt_reset_i (ctr_reset),
        .ovf_clr_i   (ovf_clr_i),
        .count_o     (count_w),
        .ovf_o       (ovf_o)
    );

    cmp_seq_fsm seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .match_i      (match),
        .tick_i       (tick_i),
        .cmp_wr_i     (cmp_wr),
        .event_mode_i (dec.event_en),
        .fire_o       (fire),
        .trig_o       (trig),
        .ctr_reset_o  (ctr_reset)
    );

    cmp_out_ctrl out_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .fire_i        (fire),
        .dec_i         (dec),
        .mode_off_wr_i (mode_off_wr),
        .oe_i          (oe_i),
        .irq_clr_i     (irq_clr_i),
        .latch_o       (latch_w),
        .pin_o         (pin_o),
        .pin_oe_o      (pin_oe_o),
        .irq_o         (irq_o)
    );

    assign count_o      = count_w;
    assign conv_start_o = trig;
endmodule

// File: rtl/cmp_timer_chk.sv
`timescale 1ns/1ps
module cmp_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       mode,
    input logic             latch,
    input logic             tick_i,
    input logic             oe_i,
    input logic [CNT_W-1:0] count_o,
    input logic             ovf_o,
    input logic             irq_o,
    input logic             pin_oe_o,
    input logic             conv_start_o
);
    assert_strobe_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> (mode == 4'b1011 && !pin_oe_o));

    assert_strobe_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> irq_o);

    assert_reset_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start_o && tick_i) |=> (count_o == '0 && !$rose(ovf_o)));

    assert_pin_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe_o |-> oe_i);

    assert_off_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'b0000) |-> !latch);

    assert_wrap_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> ($past(tick_i) && $past(count_o) == {CNT_W{1'b1}}));
endmodule

bind cmp_timer_unit cmp_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode_q),
    .latch        (latch_w),
    .tick_i       (tick_i),
    .oe_i         (oe_i),
    .count_o      (count_o),
    .ovf_o        (ovf_o),
    .irq_o        (irq_o),
    .pin_oe_o     (pin_oe_o),
    .conv_start_o (conv_start_o)
);

// File: tb/cmp_timer_unit_tb.sv
`timescale 1ns/1ps
module cmp_timer_unit_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, wr_addr = 1'b0, tick = 1'b0, oe = 1'b0;
    logic         irq_clr = 1'b0, ovf_clr = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] count;
    logic         ovf, irq, pin, pin_oe, conv;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    cmp_timer_unit #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .tick_i(tick), .oe_i(oe), .irq_clr_i(irq_clr),
        .ovf_clr_i(ovf_clr), .count_o(count), .ovf_o(ovf), .irq_o(irq),
        .pin_o(pin), .pin_oe_o(pin_oe), .conv_start_o(conv)
    );

    typedef struct packed {
        logic [3:0]   mode;
        logic         irq;
        logic         pin;
        logic         oe;
        logic         conv;
        logic [W-1:0] cnt_after;
    } vec_t;

    localparam vec_t VECS [0:6] = '{
        '{4'b0010, 1'b1, 1'b1, 1'b1, 1'b0, 16'd4},
        '{4'b1000, 1'b1, 1'b1, 1'b1, 1'b0, 16'd4},
        '{4'b1001, 1'b1, 1'b0, 1'b1, 1'b0, 16'd4},
        '{4'b1010, 1'b1, 1'b0, 1'b0, 1'b0, 16'd4},
        '{4'b1011, 1'b1, 1'b0, 1'b0, 1'b1, 16'd0},
        '{4'b0101, 1'b0, 1'b0, 1'b0, 1'b0, 16'd4},
        '{4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'd4}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic w, input logic a, input logic [W-1:0] d);
        tick = t; wr_en = w; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        tick = 1'b0; wr_en = 1'b0; irq_clr = 1'b0; ovf_clr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; oe = 1'b0;
        irq_clr = 1'b0; ovf_clr = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic setup(input logic [3:0] m, input logic [W-1:0] c);
        step(1'b0, 1'b1, 1'b0, c);
        step(1'b0, 1'b1, 1'b1, {{(W-4){1'b0}}, m});
    endtask

    initial begin
        #1_500_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        chk("reset count", 32'(count), 0);
        chk("reset R4 irq", 32'(irq), 0);
        chk("reset R12 ovf", 32'(ovf), 0);
        chk("reset R6 conv", 32'(conv), 0);
        chk("reset R10 pin", 32'(pin), 0);

        // vector table: one match at compare value 3 per mode code
        for (int i = 0; i < 7; i++) begin
            do_reset();
            oe = 1'b1;
            setup(VECS[i].mode, 16'd3);
            repeat (3) step(1'b1, 1'b0, 1'b0, '0);
            chk("R1 count at match", 32'(count), 3);
            chk("R6 R11 strobe in match cycle", 32'(conv), 32'(VECS[i].conv));
            step(1'b0, 1'b0, 1'b0, '0);
            chk("R4 R11 irq after match", 32'(irq), 32'(VECS[i].irq));
            chk("R2 R3 R5 pin after match", 32'(pin), 32'(VECS[i].pin));
            chk("R5 R10 pin_oe by mode", 32'(pin_oe), 32'(VECS[i].oe));
            chk("R6 strobe one cycle", 32'(conv), 0);
            step(1'b1, 1'b0, 1'b0, '0);
            chk("R7 R12 count after next tick", 32'(count), 32'(VECS[i].cnt_after));
            chk("R7 no ovf", 32'(ovf), 0);
        end

        // R1: no retrigger while held; R4 clear
        do_reset(); oe = 1'b1;
        setup(4'b0010, 16'd3);
        repeat (3) step(1'b1, 1'b0, 1'b0, '0);
        repeat (3) step(1'b0, 1'b0, 1'b0, '0);
        chk("R1 toggle not repeated", 32'(pin), 1);
        irq_clr = 1'b1;
        step(1'b0, 1'b0, 1'b0, '0);
        chk("R4 irq cleared", 32'(irq), 0);
        step(1'b0, 1'b0, 1'b0, '0);
        chk("R1 flag not repeated", 32'(irq), 0);
        // R12 / R2: full wrap then second toggle
        for (int k = 0; k < 65536; k++) step(1'b1, 1'b0, 1'b0, '0);
        step(1'b0, 1'b0, 1'b0, '0);
        chk("R12 count after wrap", 32'(count), 3);
        chk("R12 ovf set", 32'(ovf), 1);
        chk("R2 second toggle", 32'(pin), 0);
        chk("R4 irq second match", 32'(irq), 1);
        ovf_clr = 1'b1;
        step(1'b0, 1'b0, 1'b0, '0);
        chk("R12 ovf cleared", 32'(ovf), 0);

        // R8: rewrite compare value cancels pending reset
        do_reset(); oe = 1'b1;
        setup(4'b1011, 16'd5);
        repeat (5) step(1'b1, 1'b0, 1'b0, '0);
        chk("R6 strobe at match", 32'(conv), 1);
        step(1'b0, 1'b0, 1'b0, '0);
        step(1'b0, 1'b1, 1'b0, 16'd9);
        step(1'b1, 1'b0, 1'b0, '0);
        chk("R8 reset cancelled", 32'(count), 6);
        chk("R8 no ovf", 32'(ovf), 0);

        // R7: tick present in the match cycle
        do_reset(); oe = 1'b1;
        setup(4'b1011, 16'd5);
        repeat (5) step(1'b1, 1'b0, 1'b0, '0);
        chk("R6 strobe with tick", 32'(conv), 1);
        step(1'b1, 1'b0, 1'b0, '0);
        chk("R7 reset on match-cycle tick", 32'(count), 0);
        chk("R7 reset not overflow", 32'(ovf), 0);
        chk("R6 no pin drive", 32'(pin_oe), 0);

        // R9 / R10
        do_reset(); oe = 1'b1;
        setup(4'b1000, 16'd2);
        repeat (2) step(1'b1, 1'b0, 1'b0, '0);
        step(1'b0, 1'b0, 1'b0, '0);
        chk("R3 set latch", 32'(pin), 1);
        oe = 1'b0; #1;
        chk("R10 oe low gates pin_oe", 32'(pin_oe), 0);
        chk("R10 oe low gates pin", 32'(pin), 0);
        oe = 1'b1;
        step(1'b0, 1'b1, 1'b1, 16'h0000);
        chk("R9 mode off no drive", 32'(pin_oe), 0);
        step(1'b0, 1'b1, 1'b1, 16'h0008);
        chk("R9 latch forced low", 32'(pin), 0);
        chk("R10 drive restored", 32'(pin_oe), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule